// File: doc/BRIEF.md
# Serial Bus Master Register Front-End

This block is the software-visible control plane of a two-wire serial bus master. It holds a bank of 32-bit registers behind a simple write-enable/address bus with a combinational read path. From those registers it hands each transaction to a separate shift engine and latches the engine's completion and error report as sticky flags. It also raises an interrupt line and sequences two housekeeping operations, a controller soft reset and a slave mode-entry sequence. The shifting and the bit-clock divider live elsewhere. The front-end only supplies their configuration and talks to them over handshake pins.

Software fills in the command, the register address, the slave's runtime address and, for writes, the data. It then sets the start bit. The front-end presents the transaction on a valid/ready launch port. `eng_cmd_valid` rises one cycle after the start write and holds with a stable payload until `eng_cmd_ready` is seen high on a clock edge. The transaction counts as running until the engine pulses `eng_done`. The start bit reads back as 1 for that whole time. A `eng_done` pulse that arrives while no transaction runs is ignored. The start, soft-reset and mode-entry bits clear themselves when their operation ends.

Register offsets: control 0x00, clock setup 0x04, interrupt enable 0x08, status 0x0C, register address 0x10, data 0x1C, line control 0x24, mode entry 0x28, command 0x2C, slave address 0x30.

Top module: `sbus_regfront`

## Requirements
- R1: After reset every register reads 0, except line control, whose bits 5:4 show the live clock and data lines. `irq`, `eng_cmd_valid`, `srst_req` and `init_req` are low.
- R2: These registers read back what was written, masked to their implemented bits:
  - clock setup: divider in bits 7:0, output delay in bits 10:8, both driven on `clk_div`/`sda_delay`;
  - interrupt enable: bits 2:0;
  - register address: bits 7:0;
  - data: bits 31:0;
  - command: bits 7:0;
  - slave address: runtime address in bits 23:16 and hardware address in bits 15:0, both driven to the engine.
- R3: Writing control bit 7 while idle raises `eng_cmd_valid` on the next cycle with the command, register address, data and slave address as payload. The payload holds until `eng_cmd_ready` is seen. Control bit 7 reads 1 until the engine's `eng_done`, then reads 0.
- R4: On `eng_done` without error, status bit 0 is set. If `eng_rd_load` is also high, the data register takes `eng_rdata`. On `eng_done` with `eng_err`:
  - status bit 1 is set;
  - status bits 11:8 take `eng_err_byte`;
  - status bit 16 is set if `eng_ack_err` is high;
  - the data register is left as it was.
- R5: Status bits are cleared only by writing 1 to them. Writing 0 leaves them set.
- R6: Writing the command register or control bit 7 while a transaction runs sets status bit 2 (load busy). In that case the command register and the launch payload stay unchanged.
- R7: `irq` is high exactly when control bit 1 (global enable) is set and some status bit among 2:0 is set together with the same bit of the interrupt enable register.
- R8: Writing control bit 6 pulses `eng_abort` for one cycle on the next cycle. It ends the running transaction, drops `eng_cmd_valid` and sets no status bit.
- R9: Writing control bit 0 raises `srst_req` and bit 0 reads 1 until `srst_done`. At that point every register, the status and any running transaction return to their reset state.
- R10: Writing mode-entry bit 31 raises `init_req` until `init_done`, and bit 31 reads 1 until then. Bits 23:16 and 15:8 are kept and driven on `init_mode_data` and `init_mode_reg`.
- R11: Line control bits 3/2 drive `scl_force_val`/`scl_force_en` and bits 1/0 drive `sda_force_val`/`sda_force_en`. Bits 5/4 read the clock/data lines after `SYNC_STAGES` clock edges, and writes to bits 5/4 are ignored.
- R12: Offsets outside the map read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_cmd_valid | output | 1 | Launch request valid |
| eng_cmd_ready | input | 1 | Engine accepts launch |
| eng_cmd | output | 8 | Command code |
| eng_reg_addr | output | 8 | Slave register address |
| eng_wdata | output | 32 | Write payload |
| eng_rt_addr | output | 8 | Slave runtime address |
| eng_hw_addr | output | 16 | Slave hardware address |
| eng_abort | output | 1 | One-cycle abort pulse |
| eng_done | input | 1 | Transaction finished pulse |
| eng_err | input | 1 | Transaction failed (with `eng_done`) |
| eng_ack_err | input | 1 | Failure was an acknowledge error |
| eng_err_byte | input | 4 | Failing byte indication |
| eng_rd_load | input | 1 | `eng_rdata` holds read data |
| eng_rdata | input | 32 | Read data from the engine |
| clk_div | output | 8 | Bit-clock divider setting |
| sda_delay | output | 3 | Data output delay setting |
| scl_in | input | 1 | Live clock line (asynchronous) |
| sda_in | input | 1 | Live data line (asynchronous) |
| scl_force_en | output | 1 | Force clock line |
| scl_force_val | output | 1 | Forced clock value |
| sda_force_en | output | 1 | Force data line |
| sda_force_val | output | 1 | Forced data value |
| srst_req | output | 1 | Soft reset in progress |
| srst_done | input | 1 | Soft reset complete |
| init_req | output | 1 | Mode-entry sequence request |
| init_done | input | 1 | Mode-entry sequence complete |
| init_mode_data | output | 8 | Mode data value for the sequence |
| init_mode_reg | output | 8 | Mode register value for the sequence |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 8 and `SYNC_STAGES` = 3. The three-stage line synchroniser makes the read-back latency of the line states long enough to tell apart from a one- or two-stage chain, and the bench samples on both sides of that boundary. Random configuration writes and random transaction outcomes are each compared against a bench model of the masks and status encoding. Directed cases cover the corners: load-busy on a running transaction, abort, soft reset with a launch pending, and partial write-one-to-clear.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int REG_W   = 32;
  localparam int NFLAG   = 3;
  localparam int EBYTE_W = 4;
  localparam int DIV_W   = 8;
  localparam int DLY_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int HW_W    = 16;
  localparam int LINE_W  = 4;

  // register byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_CLK  = 'h04;
  localparam int OFF_IEN  = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_RADR = 'h10;
  localparam int OFF_DATA = 'h1C;
  localparam int OFF_LINE = 'h24;
  localparam int OFF_MODE = 'h28;
  localparam int OFF_CMD  = 'h2C;
  localparam int OFF_SADR = 'h30;

  // control bits
  localparam int C_START = 7;
  localparam int C_ABORT = 6;
  localparam int C_GIE   = 1;
  localparam int C_SRST  = 0;
  // status bits
  localparam int S_OVER  = 0;
  localparam int S_ERR   = 1;
  localparam int S_BUSY  = 2;
  localparam int S_EBYTE = 8;
  localparam int S_ACK   = 16;
  // field positions
  localparam int K_DLY   = 8;
  localparam int L_SDA   = 4;
  localparam int L_SCL   = 5;
  localparam int M_START = 31;
  localparam int M_DATA  = 16;
  localparam int M_REG   = 8;
  localparam int A_RT    = 16;

  typedef struct packed {
    logic              gie;
    logic [DIV_W-1:0]  div;
    logic [DLY_W-1:0]  dly;
    logic [NFLAG-1:0]  ien;
    logic [BYTE_W-1:0] radr;
    logic [REG_W-1:0]  data;
    logic [LINE_W-1:0] line;
    logic [BYTE_W-1:0] mdata;
    logic [BYTE_W-1:0] mreg;
    logic [BYTE_W-1:0] cmd;
    logic [BYTE_W-1:0] rt;
    logic [HW_W-1:0]   hw;
  } cfg_t;
endpackage

// File: rtl/sbus_sync.sv
module sbus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sbus_xfer_ctl.sv
module sbus_xfer_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sclr,
  input  logic start_req,
  input  logic abort_req,
  input  logic cmd_wr,
  input  logic cmd_ready,
  input  logic done,
  output logic active,
  output logic cmd_valid,
  output logic abort_pulse,
  output logic cmd_wr_ok,
  output logic busy_evt,
  output logic done_ok
);
  logic launch;

  assign launch    = start_req && !active && !abort_req;
  assign busy_evt  = (start_req || cmd_wr) && active;
  assign cmd_wr_ok = cmd_wr && !active;
  assign done_ok   = done && active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      cmd_valid   <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      abort_pulse <= abort_req && !sclr;
      if (sclr || abort_req) begin
        active    <= 1'b0;
        cmd_valid <= 1'b0;
      end else if (launch) begin
        active    <= 1'b1;
        cmd_valid <= 1'b1;
      end else begin
        if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
        if (done_ok) begin
          active    <= 1'b0;
          cmd_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sbus_status.sv
module sbus_status import sbus_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclr,
  input  logic               set_over,
  input  logic               set_err,
  input  logic               set_busy,
  input  logic               set_ack,
  input  logic [EBYTE_W-1:0] err_byte,
  input  logic               w1c_en,
  input  logic [REG_W-1:0]   w1c_data,
  input  logic [NFLAG-1:0]   flag_en,
  input  logic               gie,
  output logic [REG_W-1:0]   status,
  output logic               irq
);
  logic [NFLAG-1:0]   flags, flag_set, flag_clr;
  logic [EBYTE_W-1:0] ebyte, ebyte_clr;
  logic               ack, ack_clr;

  always_comb begin
    flag_set         = '0;
    flag_set[S_OVER] = set_over;
    flag_set[S_ERR]  = set_err;
    flag_set[S_BUSY] = set_busy;
    flag_clr  = w1c_en ? w1c_data[NFLAG-1:0] : '0;
    ebyte_clr = w1c_en ? w1c_data[S_EBYTE +: EBYTE_W] : '0;
    ack_clr   = w1c_en && w1c_data[S_ACK];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      ebyte <= '0;
      ack   <= 1'b0;
    end else if (sclr) begin
      flags <= '0;
      ebyte <= '0;
      ack   <= 1'b0;
    end else begin
      flags <= (flags & ~flag_clr) | flag_set;
      ebyte <= set_err ? err_byte : (ebyte & ~ebyte_clr);
      ack   <= set_ack || (ack && !ack_clr);
    end
  end

  always_comb begin
    status                      = '0;
    status[NFLAG-1:0]           = flags;
    status[S_EBYTE +: EBYTE_W]  = ebyte;
    status[S_ACK]               = ack;
  end

  assign irq = gie && |(flags & flag_en);
endmodule

// File: rtl/sbus_regfront.sv
module sbus_regfront import sbus_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               eng_cmd_valid,
  input  logic               eng_cmd_ready,
  output logic [BYTE_W-1:0]  eng_cmd,
  output logic [BYTE_W-1:0]  eng_reg_addr,
  output logic [REG_W-1:0]   eng_wdata,
  output logic [BYTE_W-1:0]  eng_rt_addr,
  output logic [HW_W-1:0]    eng_hw_addr,
  output logic               eng_abort,
  input  logic               eng_done,
  input  logic               eng_err,
  input  logic               eng_ack_err,
  input  logic [EBYTE_W-1:0] eng_err_byte,
  input  logic               eng_rd_load,
  input  logic [REG_W-1:0]   eng_rdata,
  output logic [DIV_W-1:0]   clk_div,
  output logic [DLY_W-1:0]   sda_delay,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               scl_force_en,
  output logic               scl_force_val,
  output logic               sda_force_en,
  output logic               sda_force_val,
  output logic               srst_req,
  input  logic               srst_done,
  output logic               init_req,
  input  logic               init_done,
  output logic [BYTE_W-1:0]  init_mode_data,
  output logic [BYTE_W-1:0]  init_mode_reg,
  output logic               irq
);
  cfg_t cfg;
  logic srst_pend, init_pend, sclr;
  logic wr_ctrl, wr_clk, wr_ien, wr_stat, wr_radr, wr_data;
  logic wr_line, wr_mode, wr_cmd, wr_sadr;
  logic active, cmd_wr_ok, busy_evt, done_ok;
  logic scl_s, sda_s;
  logic [REG_W-1:0] status;

  assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(OFF_CTRL));
  assign wr_clk  = reg_wr_en && (reg_addr == ADDR_W'(OFF_CLK));
  assign wr_ien  = reg_wr_en && (reg_addr == ADDR_W'(OFF_IEN));
  assign wr_stat = reg_wr_en && (reg_addr == ADDR_W'(OFF_STAT));
  assign wr_radr = reg_wr_en && (reg_addr == ADDR_W'(OFF_RADR));
  assign wr_data = reg_wr_en && (reg_addr == ADDR_W'(OFF_DATA));
  assign wr_line = reg_wr_en && (reg_addr == ADDR_W'(OFF_LINE));
  assign wr_mode = reg_wr_en && (reg_addr == ADDR_W'(OFF_MODE));
  assign wr_cmd  = reg_wr_en && (reg_addr == ADDR_W'(OFF_CMD));
  assign wr_sadr = reg_wr_en && (reg_addr == ADDR_W'(OFF_SADR));

  assign sclr = srst_pend && srst_done;

  sbus_xfer_ctl u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclr       (sclr),
    .start_req  (wr_ctrl && reg_wdata[C_START]),
    .abort_req  (wr_ctrl && reg_wdata[C_ABORT]),
    .cmd_wr     (wr_cmd),
    .cmd_ready  (eng_cmd_ready),
    .done       (eng_done),
    .active     (active),
    .cmd_valid  (eng_cmd_valid),
    .abort_pulse(eng_abort),
    .cmd_wr_ok  (cmd_wr_ok),
    .busy_evt   (busy_evt),
    .done_ok    (done_ok)
  );

  sbus_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclr    (sclr),
    .set_over(done_ok && !eng_err),
    .set_err (done_ok && eng_err),
    .set_busy(busy_evt),
    .set_ack (done_ok && eng_err && eng_ack_err),
    .err_byte(eng_err_byte),
    .w1c_en  (wr_stat),
    .w1c_data(reg_wdata),
    .flag_en (cfg.ien),
    .gie     (cfg.gie),
    .status  (status),
    .irq     (irq)
  );

  sbus_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s)
  );
  sbus_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      srst_pend <= 1'b0;
      init_pend <= 1'b0;
    end else if (sclr) begin
      cfg       <= '0;
      srst_pend <= 1'b0;
      init_pend <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        cfg.gie <= reg_wdata[C_GIE];
        if (reg_wdata[C_SRST]) srst_pend <= 1'b1;
      end
      if (wr_clk) begin
        cfg.div <= reg_wdata[DIV_W-1:0];
        cfg.dly <= reg_wdata[K_DLY +: DLY_W];
      end
      if (wr_ien)  cfg.ien  <= reg_wdata[NFLAG-1:0];
      if (wr_radr) cfg.radr <= reg_wdata[BYTE_W-1:0];
      if (done_ok && !eng_err && eng_rd_load) cfg.data <= eng_rdata;
      else if (wr_data)                       cfg.data <= reg_wdata;
      if (wr_line) cfg.line <= reg_wdata[LINE_W-1:0];
      if (init_pend && init_done) init_pend <= 1'b0;
      if (wr_mode) begin
        cfg.mdata <= reg_wdata[M_DATA +: BYTE_W];
        cfg.mreg  <= reg_wdata[M_REG +: BYTE_W];
        if (reg_wdata[M_START]) init_pend <= 1'b1;
      end
      if (cmd_wr_ok) cfg.cmd <= reg_wdata[BYTE_W-1:0];
      if (wr_sadr) begin
        cfg.rt <= reg_wdata[A_RT +: BYTE_W];
        cfg.hw <= reg_wdata[HW_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(OFF_CTRL): begin
        reg_rdata[C_START] = active;
        reg_rdata[C_GIE]   = cfg.gie;
        reg_rdata[C_SRST]  = srst_pend;
      end
      ADDR_W'(OFF_CLK): begin
        reg_rdata[DIV_W-1:0]       = cfg.div;
        reg_rdata[K_DLY +: DLY_W]  = cfg.dly;
      end
      ADDR_W'(OFF_IEN):  reg_rdata[NFLAG-1:0]  = cfg.ien;
      ADDR_W'(OFF_STAT): reg_rdata             = status;
      ADDR_W'(OFF_RADR): reg_rdata[BYTE_W-1:0] = cfg.radr;
      ADDR_W'(OFF_DATA): reg_rdata             = cfg.data;
      ADDR_W'(OFF_LINE): begin
        reg_rdata[LINE_W-1:0] = cfg.line;
        reg_rdata[L_SCL]      = scl_s;
        reg_rdata[L_SDA]      = sda_s;
      end
      ADDR_W'(OFF_MODE): begin
        reg_rdata[M_START]           = init_pend;
        reg_rdata[M_DATA +: BYTE_W]  = cfg.mdata;
        reg_rdata[M_REG +: BYTE_W]   = cfg.mreg;
      end
      ADDR_W'(OFF_CMD):  reg_rdata[BYTE_W-1:0] = cfg.cmd;
      ADDR_W'(OFF_SADR): begin
        reg_rdata[A_RT +: BYTE_W] = cfg.rt;
        reg_rdata[HW_W-1:0]       = cfg.hw;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign eng_cmd        = cfg.cmd;
  assign eng_reg_addr   = cfg.radr;
  assign eng_wdata      = cfg.data;
  assign eng_rt_addr    = cfg.rt;
  assign eng_hw_addr    = cfg.hw;
  assign clk_div        = cfg.div;
  assign sda_delay      = cfg.dly;
  assign scl_force_val  = cfg.line[3];
  assign scl_force_en   = cfg.line[2];
  assign sda_force_val  = cfg.line[1];
  assign sda_force_en   = cfg.line[0];
  assign srst_req       = srst_pend;
  assign init_req       = init_pend;
  assign init_mode_data = cfg.mdata;
  assign init_mode_reg  = cfg.mreg;
endmodule

// File: rtl/sbus_regfront_chk.sv
module sbus_regfront_chk import sbus_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              eng_cmd_valid,
  input logic              eng_cmd_ready,
  input logic [BYTE_W-1:0] eng_cmd,
  input logic              eng_abort,
  input logic              eng_done,
  input logic              srst_req,
  input logic              srst_done,
  input logic              init_req,
  input logic              init_done,
  input logic [3:0]        force_bits
);
  logic ctl_wr, line_wr, soft_clr;
  assign ctl_wr   = reg_wr_en && (reg_addr == ADDR_W'(OFF_CTRL));
  assign line_wr  = reg_wr_en && (reg_addr == ADDR_W'(OFF_LINE));
  assign soft_clr = srst_req && srst_done;

  AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_cmd_valid) |-> $past(ctl_wr && reg_wdata[C_START])); // R3

  AST_LAUNCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_cmd_valid && !eng_cmd_ready && !eng_done && !soft_clr
     && !(ctl_wr && reg_wdata[C_ABORT]))
    |=> (eng_cmd_valid && $stable(eng_cmd))); // R6

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort |-> $past(ctl_wr && reg_wdata[C_ABORT])); // R8

  AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_req && !srst_done) |=> srst_req); // R9

  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && !init_done) |=> init_req); // R10

  AST_FORCE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_wr && !soft_clr) |=> $stable(force_bits)); // R11
endmodule

bind sbus_regfront sbus_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .eng_cmd_valid(eng_cmd_valid),
  .eng_cmd_ready(eng_cmd_ready),
  .eng_cmd      (eng_cmd),
  .eng_abort    (eng_abort),
  .eng_done     (eng_done),
  .srst_req     (srst_req),
  .srst_done    (srst_done),
  .init_req     (init_req),
  .init_done    (init_done),
  .force_bits   ({scl_force_val, scl_force_en, sda_force_val, sda_force_en})
);

// File: tb/tb_sbus_regfront.sv
module tb_sbus_regfront;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_cmd_valid, eng_cmd_ready = 0, eng_abort;
  logic [7:0] eng_cmd, eng_reg_addr, eng_rt_addr;
  logic [31:0] eng_wdata;
  logic [15:0] eng_hw_addr;
  logic eng_done = 0, eng_err = 0, eng_ack_err = 0, eng_rd_load = 0;
  logic [3:0] eng_err_byte = 0;
  logic [31:0] eng_rdata = 0;
  logic [7:0] clk_div;
  logic [2:0] sda_delay;
  logic scl_in = 1, sda_in = 1;
  logic scl_force_en, scl_force_val, sda_force_en, sda_force_val;
  logic srst_req, srst_done = 0, init_req, init_done = 0, irq;
  logic [7:0] init_mode_data, init_mode_reg;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_regfront #(.ADDR_W(8), .SYNC_STAGES(SYNC)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int off, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = 8'(off); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(int off, output logic [31:0] d);
    reg_addr = 8'(off);
    #1;
    d = reg_rdata;
  endtask

  task automatic rchk(string req, int off, logic [31:0] exp);
    logic [31:0] v;
    rd(off, v);
    chk(req, v, exp);
  endtask

  task automatic accept();
    @(negedge clk); eng_cmd_ready = 1;
    @(negedge clk); eng_cmd_ready = 0;
  endtask

  task automatic finish_xfer(bit err, bit ack, logic [3:0] eb, bit ld, logic [31:0] rdv);
    @(negedge clk);
    eng_done = 1; eng_err = err; eng_ack_err = ack;
    eng_err_byte = eb; eng_rd_load = ld; eng_rdata = rdv;
    @(negedge clk);
    eng_done = 0; eng_err = 0; eng_ack_err = 0; eng_rd_load = 0;
  endtask

  function automatic logic [31:0] cfg_mask(int off);
    case (off)
      'h04: return 32'h0000_07FF;
      'h08: return 32'h0000_0007;
      'h10: return 32'h0000_00FF;
      'h1C: return 32'hFFFF_FFFF;
      'h2C: return 32'h0000_00FF;
      'h30: return 32'h00FF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_stat(bit err, bit ack, logic [3:0] eb);
    if (err) return 32'h2 | (32'(eb) << 8) | (32'(ack) << 16);
    return 32'h1;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int offs[6] = '{'h04, 'h08, 'h10, 'h1C, 'h2C, 'h30};
    logic [31:0] dv;
    void'($urandom(32'h1357_9BDF));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rchk("R1 ctrl", 'h00, 0); rchk("R1 clk", 'h04, 0); rchk("R1 ien", 'h08, 0);
    rchk("R1 stat", 'h0C, 0); rchk("R1 radr", 'h10, 0); rchk("R1 data", 'h1C, 0);
    rchk("R1 line", 'h24, 32'h30); rchk("R1 mode", 'h28, 0);
    rchk("R1 cmd", 'h2C, 0); rchk("R1 sadr", 'h30, 0);
    chk("R1 outs", {irq, eng_cmd_valid, srst_req, init_req}, 0);

    // R12 unmapped
    wr('h14, 32'hFFFF_FFFF); wr('h3C, 32'hFFFF_FFFF);
    rchk("R12 read14", 'h14, 0); rchk("R12 read3C", 'h3C, 0);
    rchk("R12 clk untouched", 'h04, 0); rchk("R12 data untouched", 'h1C, 0);

    // R2 random configuration
    for (int i = 0; i < 150; i++) begin
      int off = offs[$urandom % 6];
      logic [31:0] d = $urandom;
      wr(off, d);
      rchk("R2 readback", off, d & cfg_mask(off));
      if (off == 'h04) chk("R2 clk outs", {21'b0, sda_delay, clk_div}, d & 32'h7FF);
      if (off == 'h30) chk("R2 addr outs", {8'b0, eng_rt_addr, eng_hw_addr}, d & 32'hFF_FFFF);
    end

    // R3 / R6 / R4 directed transfer
    wr('h08, 0); wr('h00, 0);
    wr('h10, 32'h3A); wr('h30, 32'h002D_03A3); wr('h1C, 32'h1234_5678); wr('h2C, 32'h4E);
    wr('h00, 32'h80);
    rchk("R3 start reads 1", 'h00, 32'h80);
    chk("R3 launch", {eng_cmd_valid, eng_cmd, eng_reg_addr, eng_rt_addr}, {1'b1, 8'h4E, 8'h3A, 8'h2D});
    chk("R3 payload", eng_wdata, 32'h1234_5678);
    chk("R3 hw addr", 32'(eng_hw_addr), 32'h03A3);
    repeat (2) @(negedge clk);
    chk("R3 valid held", 32'(eng_cmd_valid), 1);
    wr('h2C, 32'h8B);
    rchk("R6 cmd kept", 'h2C, 32'h4E);
    chk("R6 payload kept", 32'(eng_cmd), 32'h4E);
    rchk("R6 busy flag", 'h0C, 32'h4);
    wr('h00, 32'h80);
    chk("R6 still one launch", 32'(eng_cmd_valid), 1);
    accept();
    chk("R3 valid dropped", 32'(eng_cmd_valid), 0);
    rchk("R3 running", 'h00, 32'h80);
    finish_xfer(0, 0, 0, 1, 32'hCAFE_F00D);
    rchk("R4 over flag", 'h0C, 32'h5);
    rchk("R4 read data", 'h1C, 32'hCAFE_F00D);
    rchk("R3 start cleared", 'h00, 0);

    // R5 W1C
    wr('h0C, 32'h4); rchk("R5 clear busy", 'h0C, 32'h1);
    wr('h0C, 32'h0); rchk("R5 zero keeps", 'h0C, 32'h1);
    wr('h0C, 32'h1); rchk("R5 clear over", 'h0C, 32'h0);

    // R4 error
    wr('h00, 32'h80); accept();
    finish_xfer(1, 1, 4'h5, 1, 32'h0BAD_0BAD);
    rchk("R4 error status", 'h0C, 32'h0001_0502);
    rchk("R4 data kept on error", 'h1C, 32'hCAFE_F00D);
    wr('h0C, 32'h100); rchk("R5 partial byte clear", 'h0C, 32'h0001_0402);
    wr('h0C, 32'hFFFF_FFFF); rchk("R5 clear all", 'h0C, 0);

    // R7 irq
    wr('h08, 32'h1); wr('h00, 32'h2);
    chk("R7 no flags", 32'(irq), 0);
    wr('h00, 32'h82); accept(); finish_xfer(0, 0, 0, 0, 0);
    #1; chk("R7 irq on", 32'(irq), 1);
    wr('h00, 32'h0); #1; chk("R7 gie off", 32'(irq), 0);
    wr('h00, 32'h2); #1; chk("R7 gie on", 32'(irq), 1);
    wr('h08, 32'h2); #1; chk("R7 enable masks", 32'(irq), 0);

    // R4 / R7 random outcomes
    for (int i = 0; i < 40; i++) begin
      bit err = 1'($urandom), ack, ld = 1'($urandom), gie = 1'($urandom);
      logic [3:0] eb;
      logic [2:0] ie = 3'($urandom);
      logic [31:0] rdv = $urandom, prev, es;
      ack = err & 1'($urandom);
      eb  = err ? 4'($urandom) : 4'h0;
      rd('h1C, prev);
      wr('h0C, 32'hFFFF_FFFF); wr('h08, 32'(ie));
      wr('h00, 32'(gie) << 1); wr('h00, (32'(gie) << 1) | 32'h80);
      accept(); finish_xfer(err, ack, eb, ld, rdv);
      es = exp_stat(err, ack, eb);
      rchk("R4 random status", 'h0C, es);
      rchk("R4 random data", 'h1C, (!err && ld) ? rdv : prev);
      chk("R7 random irq", 32'(irq), 32'(gie & |(es[2:0] & ie)));
    end

    // R8 abort
    wr('h0C, 32'hFFFF_FFFF); wr('h00, 0);
    wr('h00, 32'h80);
    wr('h00, 32'h40);
    chk("R8 abort pulse", {eng_abort, eng_cmd_valid}, 2'b10);
    @(negedge clk);
    chk("R8 pulse ends", 32'(eng_abort), 0);
    rchk("R8 idle", 'h00, 0);
    rchk("R8 no flag", 'h0C, 0);

    // R9 soft reset
    wr('h04, 32'h123); wr('h08, 32'h7); wr('h00, 32'h80);
    wr('h00, 32'h1);
    chk("R9 request", 32'(srst_req), 1);
    rchk("R9 pending read", 'h00, 32'h81);
    repeat (2) @(negedge clk);
    chk("R9 held", 32'(srst_req), 1);
    srst_done = 1; @(negedge clk); srst_done = 0;
    chk("R9 released", {srst_req, eng_cmd_valid}, 0);
    rchk("R9 ctrl", 'h00, 0); rchk("R9 clk", 'h04, 0); rchk("R9 ien", 'h08, 0);

    // R10 mode entry
    wr('h28, 32'h807C_3E00);
    chk("R10 request", {init_req, init_mode_data, init_mode_reg}, {1'b1, 8'h7C, 8'h3E});
    rchk("R10 pending read", 'h28, 32'h807C_3E00);
    repeat (2) @(negedge clk);
    chk("R10 held", 32'(init_req), 1);
    init_done = 1; @(negedge clk); init_done = 0;
    chk("R10 released", 32'(init_req), 0);
    rchk("R10 self clear", 'h28, 32'h007C_3E00);

    // R11 line control
    wr('h24, 32'h3F);
    chk("R11 force all", {scl_force_val, scl_force_en, sda_force_val, sda_force_en}, 4'hF);
    rchk("R11 read", 'h24, 32'h3F);
    wr('h24, 32'h05);
    chk("R11 force en only", {scl_force_val, scl_force_en, sda_force_val, sda_force_en}, 4'h5);
    rchk("R11 live ignore write", 'h24, 32'h35);
    sda_in = 0;
    repeat (SYNC - 1) @(negedge clk);
    rchk("R11 sync not yet", 'h24, 32'h35);
    @(negedge clk);
    rchk("R11 sync sda", 'h24, 32'h25);
    scl_in = 0;
    repeat (SYNC) @(negedge clk);
    rchk("R11 sync scl", 'h24, 32'h05);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule